// File: doc/BRIEF.md
# Four-Lane Motor Command Pulse Transmitter

This block sends digital motor-throttle frames on four output lines at the same time. Each lane has its own 11-bit throttle value and its own telemetry-request flag. When a frame starts, the block latches all four value/flag pairs and adds a 4-bit integrity nibble to each. It then shifts each 16-bit word out as a train of fixed-length slots. In each slot, the time the line stays high tells a 1 bit from a 0 bit.

A prescaler turns the system clock into a slot tick. A 2-bit rate input chooses one of four bit rates. One shared tick, slot and position counter drives all four lanes, so their bit boundaries line up exactly. The host raises `start_i` for one clock while `busy_o` is low. It then waits for the one-clock `done_o` pulse before it sends the next frame.

Top module: `motor_frame_tx`

## Requirements
- R1: Each lane's 16-bit word is laid out as the 11-bit value in bits 15..5, the telemetry flag in bit 4 and the integrity nibble in bits 3..0. The word is sent bit 15 first.
- R2: The integrity nibble is the XOR of bits 11..8, 7..4 and 3..0 of the 12-bit word {value, flag}.
- R3: A slot lasts 19 ticks and the line goes high at the first tick of every data slot. The line stays high for 14 ticks for a 1 bit and for 7 ticks for a 0 bit, then stays low for the rest of the slot.
- R4: The 16 data slots are followed by 2 slots in which every line stays low. `busy_o` stays high for exactly 18 × 19 ticks after the start is accepted.
- R5: One tick lasts D system clocks, where D = round(SYS_CLK_HZ / (rate × 19 000)). `rate_sel_i` encodes the rate as 0 = 150, 1 = 300, 2 = 600 and 3 = 1200 kbit/s.
- R6: All four lanes share one slot timing. Each lane still carries its own word.
- R7: Values and flags are latched on the accepted start. Later changes to those inputs, and any `start_i` raised while `busy_o` is high, have no effect.
- R8: `rate_sel_i` is sampled only when a start is accepted. Changes to it during a frame do not alter the tick length.
- R9: During reset and while idle, `busy_o`, `done_o` and all pulse outputs are low.
- R10: `done_o` is high for exactly one clock, in the first clock after the last reset slot ends. In that same clock `busy_o` goes low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset; the release is synchronised inside the block |
| start_i | input | 1 | Start request; accepted only while idle |
| rate_sel_i | input | 2 | Bit-rate select (0 = 150, 1 = 300, 2 = 600, 3 = 1200 kbit/s) |
| value_i | input | NCH*11 | Throttle values; lane n uses bits [n*11 +: 11] |
| telem_i | input | NCH | Telemetry-request flag for each lane |
| busy_o | output | 1 | High while a frame is being sent |
| done_o | output | 1 | One-clock pulse when a frame ends |
| pulse_o | output | NCH | Active-high pulse line for each lane |

## Verification
The bench compares every lane on every clock of each frame against a pulse train computed from the requirements. Any error in bit order, nibble XOR or high-time selection therefore shows up as mismatched cycles on the affected lane. The bench runs each of the four rates. A design that picked the wrong prescaler reload, or that read the rate live instead of latching it, would stretch or shrink the slots, and the bench also changes `rate_sel_i` in the middle of frames to catch the second fault. It scrambles values and flags right after the start and raises a second start halfway through a frame. A design that failed to latch its inputs, or that restarted while busy, would send corrupted words or stay busy past `done_o`. All-zero and all-ones values test the high-time extremes. The end of each frame is checked to the clock, which exposes an off-by-one in the slot count or a `done_o` pulse that is late or too long.

// File: rtl/mfx_pkg.sv
package mfx_pkg;

  localparam int VAL_W       = 11;
  localparam int WORD_W      = 16;
  localparam int SLOT_TICKS  = 19;
  localparam int HIGH_ZERO   = 7;
  localparam int HIGH_ONE    = 14;
  localparam int DATA_SLOTS  = 16;
  localparam int FRAME_SLOTS = 18;
  localparam int CNT_W       = 5;

  // Integrity nibble over the 12-bit {value, flag} word.
  function automatic logic [3:0] nib_fold(input logic [11:0] w);
    return w[11:8] ^ w[7:4] ^ w[3:0];
  endfunction

  function automatic int unsigned rate_kbps(input int unsigned sel);
    case (sel)
      0:       return 150;
      1:       return 300;
      2:       return 600;
      default: return 1200;
    endcase
  endfunction

  // Rounded clocks-per-tick for a given rate select; never below one.
  function automatic int unsigned tick_div(input longint unsigned clk_hz,
                                           input int unsigned sel);
    longint unsigned den;
    longint unsigned q;
    den = longint'(rate_kbps(sel)) * 1000 * SLOT_TICKS;
    q   = (clk_hz + den / 2) / den;
    if (q == 0) q = 1;
    return int'(q);
  endfunction

endpackage

// File: rtl/mfx_rst_sync.sv
module mfx_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q    <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      stage_q    <= 1'b1;
      rst_sync_n <= stage_q;
    end
  end
endmodule

// File: rtl/mfx_ticker.sv
module mfx_ticker
  import mfx_pkg::*;
#(
  parameter longint unsigned SYS_CLK_HZ = 100_000_000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [1:0]       rate_sel_i,
  output logic             load_o,
  output logic             slot_adv_o,
  output logic             busy_n_o,
  output logic [CNT_W-1:0] pos_n_o,
  output logic [CNT_W-1:0] slot_n_o,
  output logic             busy_o,
  output logic             done_o,
  output logic [CNT_W-1:0] pos_o,
  output logic [CNT_W-1:0] slot_o
);
  localparam int unsigned DIV0  = tick_div(SYS_CLK_HZ, 0);
  localparam int unsigned DIV1  = tick_div(SYS_CLK_HZ, 1);
  localparam int unsigned DIV2  = tick_div(SYS_CLK_HZ, 2);
  localparam int unsigned DIV3  = tick_div(SYS_CLK_HZ, 3);
  localparam int          DIV_W = $clog2(DIV0 + 1);
  localparam logic [CNT_W-1:0] LAST_POS  = CNT_W'(SLOT_TICKS - 1);
  localparam logic [CNT_W-1:0] LAST_SLOT = CNT_W'(FRAME_SLOTS - 1);

  logic             busy_q, busy_n;
  logic             done_q, done_n;
  logic [DIV_W-1:0] div_q, div_n, div_sel;
  logic [DIV_W-1:0] pcnt_q, pcnt_n;
  logic [CNT_W-1:0] pos_q, pos_n;
  logic [CNT_W-1:0] slot_q, slot_n;
  logic             accept, tick, cnt_en;

  always_comb begin
    case (rate_sel_i)
      2'd0:    div_sel = DIV_W'(DIV0);
      2'd1:    div_sel = DIV_W'(DIV1);
      2'd2:    div_sel = DIV_W'(DIV2);
      default: div_sel = DIV_W'(DIV3);
    endcase
  end

  assign accept = start_i && !busy_q;
  assign tick   = busy_q && (pcnt_q == div_q - 1'b1);
  assign cnt_en = accept || busy_q;

  // Next-state logic
  always_comb begin
    busy_n = busy_q;
    done_n = 1'b0;
    div_n  = div_q;
    pcnt_n = pcnt_q;
    pos_n  = pos_q;
    slot_n = slot_q;
    if (accept) begin
      busy_n = 1'b1;
      div_n  = div_sel;
      pcnt_n = '0;
      pos_n  = '0;
      slot_n = '0;
    end else if (busy_q) begin
      if (tick) begin
        pcnt_n = '0;
        if (pos_q == LAST_POS) begin
          pos_n = '0;
          if (slot_q == LAST_SLOT) begin
            busy_n = 1'b0;
            done_n = 1'b1;
            slot_n = '0;
          end else begin
            slot_n = slot_q + 1'b1;
          end
        end else begin
          pos_n = pos_q + 1'b1;
        end
      end else begin
        pcnt_n = pcnt_q + 1'b1;
      end
    end
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      div_q  <= '0;
      pcnt_q <= '0;
      pos_q  <= '0;
      slot_q <= '0;
    end else begin
      busy_q <= busy_n;
      done_q <= done_n;
      if (accept) div_q <= div_n;
      if (cnt_en) begin
        pcnt_q <= pcnt_n;
        pos_q  <= pos_n;
        slot_q <= slot_n;
      end
    end
  end

  assign load_o     = accept;
  assign slot_adv_o = tick && (pos_q == LAST_POS);
  assign busy_n_o   = busy_n;
  assign pos_n_o    = pos_n;
  assign slot_n_o   = slot_n;
  assign busy_o     = busy_q;
  assign done_o     = done_q;
  assign pos_o      = pos_q;
  assign slot_o     = slot_q;

  // R8
  div_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && $past(busy_q)) |-> $stable(div_q));
  // R3
  pos_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pos_q <= LAST_POS);
  // R4
  slot_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    slot_q <= LAST_SLOT);
  // R7
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !tick) |=> busy_q);
endmodule

// File: rtl/mfx_lane.sv
module mfx_lane
  import mfx_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [VAL_W-1:0] value_i,
  input  logic             telem_i,
  input  logic             slot_adv_i,
  input  logic             busy_n_i,
  input  logic [CNT_W-1:0] pos_n_i,
  input  logic [CNT_W-1:0] slot_n_i,
  output logic             pulse_o
);
  localparam logic [CNT_W-1:0] HI0    = CNT_W'(HIGH_ZERO);
  localparam logic [CNT_W-1:0] HI1    = CNT_W'(HIGH_ONE);
  localparam logic [CNT_W-1:0] NDATA  = CNT_W'(DATA_SLOTS);

  logic [WORD_W-1:0] shreg_q, shreg_n;
  logic [11:0]       body;
  logic [CNT_W-1:0]  hi_len;
  logic              pulse_q, pulse_n;
  logic              sh_en;

  assign body  = {value_i, telem_i};
  assign sh_en = load_i || slot_adv_i;

  // Next-state logic
  always_comb begin
    shreg_n = shreg_q;
    if (load_i)          shreg_n = {body, nib_fold(body)};
    else if (slot_adv_i) shreg_n = {shreg_q[WORD_W-2:0], 1'b0};
    hi_len  = shreg_n[WORD_W-1] ? HI1 : HI0;
    pulse_n = busy_n_i && (slot_n_i < NDATA) && (pos_n_i < hi_len);
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg_q <= '0;
      pulse_q <= 1'b0;
    end else begin
      if (sh_en) shreg_q <= shreg_n;
      pulse_q <= pulse_n;
    end
  end

  assign pulse_o = pulse_q;

  // R3
  first_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> pulse_q);
endmodule

// File: rtl/motor_frame_tx.sv
module motor_frame_tx
  import mfx_pkg::*;
#(
  parameter int              NCH        = 4,
  parameter longint unsigned SYS_CLK_HZ = 100_000_000
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start_i,
  input  logic [1:0]         rate_sel_i,
  input  logic [NCH*VAL_W-1:0] value_i,
  input  logic [NCH-1:0]     telem_i,
  output logic               busy_o,
  output logic               done_o,
  output logic [NCH-1:0]     pulse_o
);
  localparam logic [CNT_W-1:0] NDATA = CNT_W'(DATA_SLOTS);

  logic             rst_sync_n;
  logic             load, slot_adv, busy_n;
  logic [CNT_W-1:0] pos_n, slot_n, pos_q, slot_q;

  mfx_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  mfx_ticker #(.SYS_CLK_HZ(SYS_CLK_HZ)) u_tick (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .start_i    (start_i),
    .rate_sel_i (rate_sel_i),
    .load_o     (load),
    .slot_adv_o (slot_adv),
    .busy_n_o   (busy_n),
    .pos_n_o    (pos_n),
    .slot_n_o   (slot_n),
    .busy_o     (busy_o),
    .done_o     (done_o),
    .pos_o      (pos_q),
    .slot_o     (slot_q)
  );

  for (genvar g = 0; g < NCH; g++) begin : g_lane
    mfx_lane u_lane (
      .clk        (clk),
      .rst_n      (rst_sync_n),
      .load_i     (load),
      .value_i    (value_i[g*VAL_W +: VAL_W]),
      .telem_i    (telem_i[g]),
      .slot_adv_i (slot_adv),
      .busy_n_i   (busy_n),
      .pos_n_i    (pos_n),
      .slot_n_i   (slot_n),
      .pulse_o    (pulse_o[g])
    );
  end

  // R9
  idle_low_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !busy_o |-> (pulse_o == '0));
  // R10
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    done_o |=> !done_o);
  // R10
  done_end_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    done_o |-> (!busy_o && $past(busy_o)));
  // R6
  lanes_aligned_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (busy_o && pos_q == '0 && slot_q < NDATA) |-> (pulse_o == '1));
  // R4
  reset_slots_low_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (busy_o && slot_q >= NDATA) |-> (pulse_o == '0));
endmodule

// File: tb/motor_frame_tx_tb.sv
module motor_frame_tx_tb;
  localparam int NCH = 4;
  localparam int VW  = 11;
  localparam longint unsigned CLK_HZ = 100_000_000;

  logic            clk = 1'b0;
  logic            rst_n;
  logic            start;
  logic [1:0]      rate;
  logic [NCH*VW-1:0] value;
  logic [NCH-1:0]  telem;
  logic            busy, done;
  logic [NCH-1:0]  pulse;

  int errors = 0;
  int checks = 0;

  always #5 clk = ~clk;

  motor_frame_tx #(.NCH(NCH), .SYS_CLK_HZ(CLK_HZ)) u_dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start),
    .rate_sel_i (rate),
    .value_i    (value),
    .telem_i    (telem),
    .busy_o     (busy),
    .done_o     (done),
    .pulse_o    (pulse)
  );

  function automatic logic [15:0] word_of(input logic [10:0] v, input logic t);
    logic [11:0] b;
    b = {v, t};
    return {b, b[11:8] ^ b[7:4] ^ b[3:0]};
  endfunction

  function automatic int exp_div(input logic [1:0] sel);
    longint unsigned kb, den;
    kb  = (sel == 0) ? 150 : (sel == 1) ? 300 : (sel == 2) ? 600 : 1200;
    den = kb * 19000;
    return int'((CLK_HZ + den / 2) / den);
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic run_frame(input logic [NCH*VW-1:0] v, input logic [NCH-1:0] t,
                           input logic [1:0] sel, input bit disturb);
    int div, len;
    int bad [NCH];
    int busy_bad;
    logic [15:0] w [NCH];
    div = exp_div(sel);
    len = 342 * div;
    busy_bad = 0;
    for (int n = 0; n < NCH; n++) begin
      bad[n] = 0;
      w[n] = word_of(v[n*VW +: VW], t[n]);
    end
    @(negedge clk);
    start = 1'b1; value = v; telem = t; rate = sel;
    for (int k = 0; k < len; k++) begin
      @(negedge clk);
      for (int n = 0; n < NCH; n++) begin
        int ti, sl, ps;
        logic e;
        ti = k / div; sl = ti / 19; ps = ti % 19;
        e = (sl < 16) && (ps < (w[n][15 - sl] ? 14 : 7));
        if (pulse[n] !== e) bad[n]++;
      end
      if (busy !== 1'b1 || done !== 1'b0) busy_bad++;
      if (k == 0) begin
        start = 1'b0; value = ~v; telem = ~t; rate = sel + 2'd1;
      end
      if (disturb && k == len / 2)     begin start = 1'b1; rate = sel ^ 2'd1; end
      if (disturb && k == len / 2 + 1) start = 1'b0;
    end
    // R1 R2 R3 R6 R7 R8: every lane matches its own expected train
    for (int n = 0; n < NCH; n++)
      check(bad[n] == 0, "R1/R2/R3/R6", $sformatf("lane %0d mismatched cycles", n), bad[n], 0);
    // R4 R5: busy for exactly 342 ticks of the selected length
    check(busy_bad == 0, "R4/R5", "cycles with busy low or done high inside frame", busy_bad, 0);
    @(negedge clk);
    check(done === 1'b1 && busy === 1'b0, "R10", "done/busy at frame end",
          {30'd0, done, busy}, 2);
    check(pulse === '0, "R9", "pulses after frame", pulse, 0);
    @(negedge clk);
    // R7: a mid-frame start did not launch a second frame
    check(done === 1'b0 && busy === 1'b0, "R10/R7", "done/busy one clock later",
          {30'd0, done, busy}, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL R4 watchdog expired actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    rst_n = 1'b0; start = 1'b0; rate = 2'd3; value = '0; telem = '0;
    repeat (3) @(negedge clk);
    // R9: reset state
    check(busy === 1'b0 && done === 1'b0 && pulse === '0, "R9", "outputs during reset",
          {27'd0, busy, done, pulse}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(busy === 1'b0 && done === 1'b0 && pulse === '0, "R9", "outputs idle after reset",
          {27'd0, busy, done, pulse}, 0);

    // Directed corner cases
    run_frame('0, 4'b0000, 2'd3, 1'b0);                       // all zero bits
    run_frame({NCH{11'h7FF}}, 4'b1111, 2'd3, 1'b0);           // all ones
    run_frame({11'd800, 11'd600, 11'd400, 11'd200}, 4'b0101, 2'd3, 1'b1);
    run_frame({11'h555, 11'h2AA, 11'h001, 11'h400}, 4'b1010, 2'd2, 1'b1);
    run_frame({11'h123, 11'h456, 11'h789, 11'h0AB}, 4'b0011, 2'd1, 1'b0);
    run_frame({11'h3C3, 11'h0F0, 11'h70E, 11'h1FF}, 4'b1100, 2'd0, 1'b1);

    // Constrained random frames at the fastest rates
    for (int i = 0; i < 6; i++) begin
      logic [NCH*VW-1:0] rv;
      for (int n = 0; n < NCH; n++) rv[n*VW +: VW] = 11'($urandom_range(0, 2047));
      run_frame(rv, 4'($urandom_range(0, 15)), 2'($urandom_range(2, 3)), 1'($urandom_range(0, 1)));
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule